// File: doc/BRIEF.md
# Static memory strobe timing generator

This block runs single read or write accesses on an external static-memory bus. A host presents a request with direction, address and write data, and the block walks one access through a programmable cycle: it puts the address on the bus, lowers a chip select and either a read strobe or a write strobe at programmed points, and raises them again at programmed points. It enables the write-data drivers for the whole of a write. All strobes are active low.

Timing is set by compact coded fields that arrive on input ports. Each field expands to an effective count of clock cycles with a jump in the middle of its range. This gives long intervals without wide fields. Reads and writes each have their own cycle length. The chip select and the data strobe each have their own setup and pulse, and every interval is measured from the first cycle in which the new address is on the bus. When a read directly follows a write, the block inserts one quiet cycle to keep the data bus free of contention. An access whose fields are inconsistent is still carried out, but it is flagged on an error output while it runs.

Top module: `smem_strobe_gen`

## Requirements
- R1: The 6-bit setup code c gives an effective setup of 128*c[5] + c[4:0] cycles. A strobe or chip select goes low in access cycle number equal to its effective setup, where cycle 0 is the first cycle with the new address on the bus.
- R2: The 7-bit pulse code c gives an effective pulse of 256*c[6] + c[5:0] cycles. The strobe or chip select stays low for exactly that many cycles, but never beyond the end of the access.
- R3: The 9-bit cycle code c gives an access length of 256*c[8:7] + c[6:0] cycles. `ack` is high for exactly one cycle, in the cycle that follows the last access cycle.
- R4: A read uses the read setup, pulse and cycle fields and keeps `mem_wr_n` high. A write uses the write fields and keeps `mem_rd_n` high. The chip select follows its own setup and pulse, independently of the data strobe.
- R5: `rdata` takes the value of `mem_din` sampled at the clock edge where `mem_rd_n` returns high. It stays unchanged through later writes until the next read captures a new value.
- R6: During every cycle of a write access, `mem_doe` is high and `mem_dout` equals the request's write data. `mem_doe` is low at all other times.
- R7: `mem_addr` equals the request address from access cycle 0 to the last access cycle.
- R8: A read request accepted in the cycle right after a write's `ack` starts one cycle later than it otherwise would. In that extra cycle, all strobes are high and `mem_doe` is low. A read that follows a read, or that follows an idle cycle with `req` low, gets no extra cycle.
- R9: `cfg_err` is high during every cycle of an access whose chip-select or strobe pulse is zero, or whose setup plus pulse exceeds the cycle length. It is low otherwise. Such an access still runs its programmed cycle length.
- R10: While reset is asserted and after it is released, the strobes are high and `mem_doe`, `ack`, `cfg_err` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request; held with its fields until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| cfg_err | output | 1 | Current access has inconsistent timing fields |
| rd_setup_strb | input | 6 | Read strobe setup code |
| rd_setup_cs | input | 6 | Chip-select setup code for reads |
| rd_pulse_strb | input | 7 | Read strobe pulse code |
| rd_pulse_cs | input | 7 | Chip-select pulse code for reads |
| rd_cycle | input | 9 | Read cycle length code |
| wr_setup_strb | input | 6 | Write strobe setup code |
| wr_setup_cs | input | 6 | Chip-select setup code for writes |
| wr_pulse_strb | input | 7 | Write strobe pulse code |
| wr_pulse_cs | input | 7 | Chip-select pulse code for writes |
| wr_cycle | input | 9 | Write cycle length code |
| mem_addr | output | AW | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_dout | output | DW | Write data to memory |
| mem_doe | output | 1 | Write data output enable |
| mem_din | input | DW | Read data from memory |

## Verification
The hardest case to reach is the write-to-read turnaround. It happens only when a read request is already waiting in the single idle cycle that carries a write's `ack`. If the host waits even one more cycle, the quiet cycle is no longer due. To reach it, the bench presents the next request at the very sampling instant where it sees `ack`. It alternates sweep points between a back-to-back write-then-read pair and a read preceded by an idle gap, so both sides of R8 are checked. The upper halves of the coded ranges are reached with a few long accesses built from the high code bits.

// File: rtl/smem_strobe_gen.sv
module smem_strobe_gen #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          cfg_err,
  input  logic [5:0]    rd_setup_strb,
  input  logic [5:0]    rd_setup_cs,
  input  logic [6:0]    rd_pulse_strb,
  input  logic [6:0]    rd_pulse_cs,
  input  logic [8:0]    rd_cycle,
  input  logic [5:0]    wr_setup_strb,
  input  logic [5:0]    wr_setup_cs,
  input  logic [6:0]    wr_pulse_strb,
  input  logic [6:0]    wr_pulse_cs,
  input  logic [8:0]    wr_cycle,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic [DW-1:0] mem_dout,
  output logic          mem_doe,
  input  logic [DW-1:0] mem_din
);

  localparam int SE = 8;
  localparam int PE = 9;
  localparam int CE = 10;
  localparam int NW = CE + 1;

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_ACC} state_t;

  function automatic logic [SE-1:0] dec_setup(input logic [5:0] c);
    return {c[5], 2'b00, c[4:0]};
  endfunction

  function automatic logic [PE-1:0] dec_pulse(input logic [6:0] c);
    return {c[6], 2'b00, c[5:0]};
  endfunction

  function automatic logic [CE-1:0] dec_cycle(input logic [8:0] c);
    return {c[8:7], 1'b0, c[6:0]};
  endfunction

  function automatic logic bad_cfg(input logic [SE-1:0] s, input logic [PE-1:0] p,
                                   input logic [CE-1:0] c);
    return (p == '0) || (({3'b000, s} + {2'b00, p}) > {1'b0, c});
  endfunction

  state_t        st;
  logic [CE-1:0] cnt;
  logic          we_q, err_q, ack_q, last_wr;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [SE-1:0] s_st, s_cs;
  logic [PE-1:0] p_st, p_cs;
  logic [CE-1:0] cyc;

  logic [SE-1:0] nx_s_st, nx_s_cs;
  logic [PE-1:0] nx_p_st, nx_p_cs;
  logic [CE-1:0] nx_cyc;
  logic          nx_err;

  assign nx_s_st = req_we ? dec_setup(wr_setup_strb) : dec_setup(rd_setup_strb);
  assign nx_s_cs = req_we ? dec_setup(wr_setup_cs)   : dec_setup(rd_setup_cs);
  assign nx_p_st = req_we ? dec_pulse(wr_pulse_strb) : dec_pulse(rd_pulse_strb);
  assign nx_p_cs = req_we ? dec_pulse(wr_pulse_cs)   : dec_pulse(rd_pulse_cs);
  assign nx_cyc  = req_we ? dec_cycle(wr_cycle)      : dec_cycle(rd_cycle);
  assign nx_err  = bad_cfg(nx_s_st, nx_p_st, nx_cyc) | bad_cfg(nx_s_cs, nx_p_cs, nx_cyc);

  logic [NW-1:0] k11, st_end, cs_end;
  logic          busy, fin, st_on, cs_on, cap;

  assign busy   = (st == S_ACC);
  assign k11    = {1'b0, cnt};
  assign st_end = {3'b000, s_st} + {2'b00, p_st};
  assign cs_end = {3'b000, s_cs} + {2'b00, p_cs};
  assign st_on  = (k11 >= {3'b000, s_st}) && (k11 < st_end);
  assign cs_on  = (k11 >= {3'b000, s_cs}) && (k11 < cs_end);
  assign fin    = (k11 + 11'd1) >= {1'b0, cyc};
  assign cap    = busy && !we_q && ((k11 + 11'd1) == st_end);

  assign mem_addr = addr_q;
  assign mem_dout = wdata_q;
  assign mem_doe  = busy && we_q;
  assign mem_cs_n = !(busy && cs_on);
  assign mem_rd_n = !(busy && !we_q && st_on);
  assign mem_wr_n = !(busy && we_q && st_on);
  assign ack      = ack_q;
  assign rdata    = rdata_q;
  assign cfg_err  = busy && err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      we_q    <= 1'b0;
      err_q   <= 1'b0;
      ack_q   <= 1'b0;
      last_wr <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      s_st    <= '0;
      s_cs    <= '0;
      p_st    <= '0;
      p_cs    <= '0;
      cyc     <= '0;
    end else begin
      ack_q <= 1'b0;
      case (st)
        S_IDLE: begin
          last_wr <= 1'b0;
          if (req) begin
            we_q    <= req_we;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            s_st    <= nx_s_st;
            s_cs    <= nx_s_cs;
            p_st    <= nx_p_st;
            p_cs    <= nx_p_cs;
            cyc     <= nx_cyc;
            err_q   <= nx_err;
            cnt     <= '0;
            st      <= (!req_we && last_wr) ? S_TURN : S_ACC;
          end
        end
        S_TURN: st <= S_ACC;
        S_ACC: begin
          if (fin) begin
            st      <= S_IDLE;
            ack_q   <= 1'b1;
            last_wr <= we_q;
          end else begin
            cnt <= cnt + 10'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (cap) rdata_q <= mem_din;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n)); // R4

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R3

  AST_ACK_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(busy)); // R3

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_ACC) |-> (mem_cs_n && mem_rd_n && mem_wr_n && !mem_doe)); // R8

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |-> $stable(mem_addr)); // R7

  AST_DOE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe |-> mem_rd_n); // R6

  AST_RDATA_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we_q) |=> $stable(rdata)); // R5

endmodule

// File: tb/sim_smem_strobe_gen.sv
`timescale 1ns/1ps
module sim_smem_strobe_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req = 0, req_we = 0;
  logic [15:0] req_addr = 0, req_wdata = 0, mem_din = 0;
  logic [5:0] rd_setup_strb = 0, rd_setup_cs = 0, wr_setup_strb = 0, wr_setup_cs = 0;
  logic [6:0] rd_pulse_strb = 1, rd_pulse_cs = 1, wr_pulse_strb = 1, wr_pulse_cs = 1;
  logic [8:0] rd_cycle = 1, wr_cycle = 1;
  logic ack, cfg_err, mem_cs_n, mem_rd_n, mem_wr_n, mem_doe;
  logic [15:0] rdata, mem_addr, mem_dout;

  smem_strobe_gen #(.AW(16), .DW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .cfg_err(cfg_err),
    .rd_setup_strb(rd_setup_strb), .rd_setup_cs(rd_setup_cs),
    .rd_pulse_strb(rd_pulse_strb), .rd_pulse_cs(rd_pulse_cs), .rd_cycle(rd_cycle),
    .wr_setup_strb(wr_setup_strb), .wr_setup_cs(wr_setup_cs),
    .wr_pulse_strb(wr_pulse_strb), .wr_pulse_cs(wr_pulse_cs), .wr_cycle(wr_cycle),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit prev_w = 0;
  logic [15:0] last_rd = 0;

  function automatic int e_setup(input logic [5:0] c);
    return 128 * c[5] + int'(c[4:0]);
  endfunction
  function automatic int e_pulse(input logic [6:0] c);
    return 256 * c[6] + int'(c[5:0]);
  endfunction
  function automatic int e_cycle(input logic [8:0] c);
    return 256 * int'(c[8:7]) + int'(c[6:0]);
  endfunction
  function automatic logic [15:0] pat(input int k, input logic [15:0] a);
    return 16'h3C00 ^ (a << 4) ^ 16'(k);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    req = 0;
    for (int i = 0; i < n; i++) @(negedge clk);
    prev_w = 0;
  endtask

  task automatic acc(input bit w, input logic [15:0] a, input logic [15:0] d);
    int ss, ps, sc, pc, cy, cend;
    bit err, turn;
    logic [15:0] exp_rd;
    logic [5:0] got, exp;
    ss = w ? e_setup(wr_setup_strb) : e_setup(rd_setup_strb);
    sc = w ? e_setup(wr_setup_cs)   : e_setup(rd_setup_cs);
    ps = w ? e_pulse(wr_pulse_strb) : e_pulse(rd_pulse_strb);
    pc = w ? e_pulse(wr_pulse_cs)   : e_pulse(rd_pulse_cs);
    cy = w ? e_cycle(wr_cycle)      : e_cycle(rd_cycle);
    cend = (cy < 1) ? 1 : cy;
    err = (ps == 0) || (pc == 0) || (ss + ps > cy) || (sc + pc > cy);
    turn = !w && prev_w;
    exp_rd = last_rd;
    if (!w && ss + ps >= 1 && ss + ps <= cend) exp_rd = pat(ss + ps - 1, a);
    req = 1; req_we = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (turn) begin
      got = {mem_cs_n, mem_rd_n, mem_wr_n, mem_doe, cfg_err, ack};
      chk(got == 6'b111000, "R8 turnaround cycle quiet", 32'(got), 32'(6'b111000));
      @(negedge clk);
    end
    for (int k = 0; k < cend; k++) begin
      exp[5] = !(k >= sc && k < sc + pc);
      exp[4] = !(!w && k >= ss && k < ss + ps);
      exp[3] = !(w && k >= ss && k < ss + ps);
      exp[2] = w;
      exp[1] = err;
      exp[0] = 1'b0;
      got = {mem_cs_n, mem_rd_n, mem_wr_n, mem_doe, cfg_err, ack};
      chk(got == exp, "R1,R2,R3,R4,R6,R9 strobe/enable/error vector", 32'(got), 32'(exp));
      chk(mem_addr == a, "R7 address held", 32'(mem_addr), 32'(a));
      if (w) chk(mem_dout == d, "R6 write data driven", 32'(mem_dout), 32'(d));
      mem_din = pat(k, a);
      @(negedge clk);
    end
    got = {mem_cs_n, mem_rd_n, mem_wr_n, mem_doe, cfg_err, ack};
    chk(got == 6'b111001, "R3 ack after last cycle", 32'(got), 32'(6'b111001));
    chk(rdata == exp_rd, "R5 read data captured/held", 32'(rdata), 32'(exp_rd));
    last_rd = exp_rd;
    prev_w = w;
    req = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    chk({mem_cs_n, mem_rd_n, mem_wr_n, mem_doe, cfg_err, ack} == 6'b111000,
        "R10 outputs in reset", 32'({mem_cs_n, mem_rd_n, mem_wr_n, mem_doe, cfg_err, ack}), 32'(6'b111000));
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk({mem_cs_n, mem_rd_n, mem_wr_n, mem_doe, cfg_err, ack} == 6'b111000 && rdata == 0,
        "R10 outputs after reset", 32'({rdata, mem_cs_n, mem_rd_n, mem_wr_n, mem_doe, cfg_err, ack}), 32'(6'b111000));

    // R1 R2 R3 R4 R5 R8: read sweep, alternating back-to-back write-then-read and gapped read
    wr_setup_strb = 1; wr_setup_cs = 0; wr_pulse_strb = 2; wr_pulse_cs = 4; wr_cycle = 5;
    idx = 0;
    for (int ss = 0; ss < 4; ss++)
      for (int sc = 0; sc < 3; sc++)
        for (int ps = 1; ps < 4; ps++)
          for (int pc = 1; pc < 3; pc++)
            for (int h = 0; h < 2; h++) begin
              rd_setup_strb = 6'(ss); rd_setup_cs = 6'(sc);
              rd_pulse_strb = 7'(ps); rd_pulse_cs = 7'(pc);
              rd_cycle = 9'((ss + ps > sc + pc ? ss + ps : sc + pc) + h);
              idx++;
              if (idx % 2 == 1) acc(1'b1, 16'(16'h1000 + idx), 16'(16'hA500 ^ idx));
              else idle(2);
              acc(1'b0, 16'(16'h2000 + idx), 16'h0);
            end

    // R6 R4: write sweep, back-to-back writes
    for (int ws = 0; ws < 3; ws++)
      for (int wc = 0; wc < 2; wc++)
        for (int wp = 1; wp < 3; wp++)
          for (int wpc = 1; wpc < 3; wpc++)
            for (int h = 0; h < 2; h++) begin
              wr_setup_strb = 6'(ws); wr_setup_cs = 6'(wc);
              wr_pulse_strb = 7'(wp); wr_pulse_cs = 7'(wpc);
              wr_cycle = 9'((ws + wp > wc + wpc ? ws + wp : wc + wpc) + h);
              acc(1'b1, 16'(16'h3000 + ws * 16 + wc * 4 + wp), 16'(16'h5A00 + wpc * 8 + h));
            end

    // R8: read right after write, then read right after read (no extra cycle)
    rd_setup_strb = 2; rd_setup_cs = 1; rd_pulse_strb = 3; rd_pulse_cs = 5; rd_cycle = 7;
    acc(1'b1, 16'h4001, 16'h1234);
    acc(1'b0, 16'h4002, 16'h0);
    acc(1'b0, 16'h4003, 16'h0);

    // R1 R2 R3 R5: upper halves of the coded ranges
    rd_setup_strb = 6'b100001; rd_pulse_strb = 7'b1000010;
    rd_setup_cs = 6'b000011; rd_pulse_cs = 7'b1000000;
    rd_cycle = 9'b100000011;
    idle(1);
    acc(1'b0, 16'h7777, 16'h0);
    wr_setup_strb = 6'b100000; wr_pulse_strb = 7'b1000001;
    wr_setup_cs = 6'b000010; wr_pulse_cs = 7'b0111111;
    wr_cycle = 9'b110000001;
    acc(1'b1, 16'h7778, 16'hBEEF);
    rd_cycle = 9'b010000000;
    rd_setup_strb = 6'b011111; rd_pulse_strb = 7'b0111111; rd_setup_cs = 0; rd_pulse_cs = 7'b1000101;
    idle(1);
    acc(1'b0, 16'h7779, 16'h0);

    // R9: illegal fields flagged, access still runs its length
    rd_setup_strb = 1; rd_pulse_strb = 2; rd_setup_cs = 0; rd_pulse_cs = 0; rd_cycle = 4;
    idle(1);
    acc(1'b0, 16'h6001, 16'h0);
    wr_setup_strb = 3; wr_pulse_strb = 4; wr_setup_cs = 0; wr_pulse_cs = 2; wr_cycle = 5;
    acc(1'b1, 16'h6002, 16'hC0DE);
    rd_setup_strb = 0; rd_pulse_strb = 2; rd_setup_cs = 2; rd_pulse_cs = 3; rd_cycle = 4;
    idle(1);
    acc(1'b0, 16'h6003, 16'h0);
    rd_pulse_cs = 2;
    acc(1'b0, 16'h6004, 16'h0);
    idle(2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule